// File: doc/BRIEF.md
# Masked-Descriptor Segment Address Translator

This block turns the upper bits of a logical bus address into a physical address by comparing them against a bank of segment descriptors. Each descriptor holds a logical base and a logical mask, a physical base, a task number and a task-number mask, an enable flag and a write-protect flag. A per-bit mask marks which bits of the logical address, and which bits of the task number, must match. Clear bits are don't-care, so a segment's size is set by how many low mask bits are clear. The task number for a bus cycle comes from a small table that the 4-bit cycle type code indexes.

For every sampled cycle the block reports one of three outcomes: a mapped physical address, a write violation, or an access to an undefined segment. When one or more descriptors hit, the lowest-numbered one wins. A successful translation marks its descriptor as used. A successful write also marks it as modified. These two flags can be read back by index. Descriptors and table entries are loaded through simple write ports.

Top module: `seg_xlate_top`

## Requirements
- R1: The space table holds 16 eight-bit entries and is written at byte addresses 0x00, 0x02, ..., 0x1E, where address 2k loads entry k. A write to an odd address changes nothing. The cycle's space number is the entry selected by the 4-bit cycle type code.
- R2: A descriptor's address test passes when the logical address equals the logical base in every bit where the logical mask is 1. Bits where the mask is 0 are ignored.
- R3: A descriptor's space test passes when the cycle space number equals the descriptor's space number in every bit where the space mask is 1. A space mask of 0x00 matches every space.
- R4: A descriptor whose enable flag is 0 never hits.
- R5: Physical address bit n takes the physical base bit where logical mask bit n is 1, and the logical address bit where it is 0.
- R6: When several descriptors hit, the one with the lowest index is used, and its index appears on `hit_idx`.
- R7: A write that hits a write-protected descriptor sets `fault` and `wr_viol`, and leaves `pa_valid` and `wr_inhibit` low.
- R8: A read that hits a write-protected descriptor gives `pa_valid` together with `wr_inhibit`. A hit on an unprotected descriptor leaves `wr_inhibit` low.
- R9: When no enabled descriptor hits, `undef_seg` and `fault` are high and `pa_valid` is low.
- R10: A successful translation sets the used flag of the chosen descriptor, and a successful write also sets its modified flag. The flags are updated only in the first cycle of each `xl_valid` assertion. Loading a descriptor clears both of its flags.
- R11: The results are registered, so they appear one clock after the cycle in which `xl_valid` is sampled high. After reset, and one clock after `xl_valid` is sampled low, every result output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| desc_wr_en | input | 1 | Load descriptor strobe |
| desc_wr_idx | input | 5 | Descriptor index to load |
| desc_wr_lbase | input | 16 | Logical base |
| desc_wr_lmask | input | 16 | Logical mask (1 = compare) |
| desc_wr_pbase | input | 16 | Physical base |
| desc_wr_space | input | 8 | Task number |
| desc_wr_smask | input | 8 | Task-number mask (1 = compare) |
| desc_wr_enable | input | 1 | Descriptor takes part in matching |
| desc_wr_wprot | input | 1 | Descriptor is write-protected |
| tbl_wr_en | input | 1 | Space table write strobe |
| tbl_wr_addr | input | 5 | Space table byte address |
| tbl_wr_data | input | 8 | Space table entry value |
| xl_valid | input | 1 | Address valid |
| xl_fc | input | 4 | Cycle type code |
| xl_laddr | input | 16 | Logical address upper bits |
| xl_write | input | 1 | Cycle is a write |
| stat_rd_idx | input | 5 | Descriptor whose flags are read |
| stat_used | output | 1 | Used flag of `stat_rd_idx` |
| stat_mod | output | 1 | Modified flag of `stat_rd_idx` |
| pa_out | output | 16 | Physical address |
| pa_valid | output | 1 | Mapped address valid |
| wr_inhibit | output | 1 | Hit on a write-protected segment |
| fault | output | 1 | Write violation or undefined segment |
| wr_viol | output | 1 | Write violation |
| undef_seg | output | 1 | No descriptor hit |
| hit_idx | output | 5 | Index of the chosen descriptor |

## Verification
All result outputs are due exactly one clock after the edge that samples `xl_valid`, `xl_fc`, `xl_laddr` and `xl_write`. The bench changes its inputs on the falling edge and reads results on the next falling edge, which is half a period after that capturing edge. The used and modified flags change at the same capturing edge. They are read combinationally through `stat_rd_idx` at that same falling edge. Table and descriptor loads take effect at the edge that samples them, so a translation issued on the next cycle already sees the new contents.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
    localparam int LA_W    = 16;
    localparam int SPACE_W = 8;

    typedef struct packed {
        logic [LA_W-1:0]    lbase;
        logic [LA_W-1:0]    lmask;
        logic [LA_W-1:0]    pbase;
        logic [SPACE_W-1:0] space;
        logic [SPACE_W-1:0] smask;
        logic               enable;
        logic               wprot;
    } desc_t;
endpackage

// File: rtl/seg_space_table.sv
module seg_space_table #(
    parameter int FC_W = 4
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en,
    input  logic [FC_W:0]                       wr_addr,
    input  logic [seg_xlate_pkg::SPACE_W-1:0]   wr_data,
    input  logic [FC_W-1:0]                     rd_fc,
    output logic [seg_xlate_pkg::SPACE_W-1:0]   rd_space
);
    import seg_xlate_pkg::*;
    localparam int ENTRIES = 1 << FC_W;

    logic [SPACE_W-1:0] tbl_d [ENTRIES];
    logic [SPACE_W-1:0] tbl_q [ENTRIES];

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) tbl_d[i] = tbl_q[i];
        // Even byte addresses only: entry index is address divided by two
        if (wr_en && !wr_addr[0]) tbl_d[wr_addr[FC_W:1]] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) tbl_q[i] <= '0;
        end else begin
            for (int i = 0; i < ENTRIES; i++) tbl_q[i] <= tbl_d[i];
        end
    end

    assign rd_space = tbl_q[rd_fc];

    // R1: an odd-address write leaves the addressed pair of entries untouched
    assert_odd_write_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr[0]) |=> (tbl_q[$past(wr_addr[FC_W:1])] == $past(tbl_q[wr_addr[FC_W:1]])));
endmodule

// File: rtl/seg_desc_store.sv
module seg_desc_store #(
    parameter int NUM_DESC = 32,
    localparam int IDX_W = $clog2(NUM_DESC)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load_en,
    input  logic [IDX_W-1:0]           load_idx,
    input  seg_xlate_pkg::desc_t       load_desc,
    input  logic                       mark_used,
    input  logic                       mark_mod,
    input  logic [IDX_W-1:0]           mark_idx,
    input  logic [IDX_W-1:0]           stat_idx,
    output logic                       stat_used,
    output logic                       stat_mod,
    output seg_xlate_pkg::desc_t       descs [NUM_DESC]
);
    import seg_xlate_pkg::*;

    desc_t              desc_d [NUM_DESC];
    desc_t              desc_q [NUM_DESC];
    logic [NUM_DESC-1:0] used_d, used_q, mod_d, mod_q;

    always_comb begin
        used_d = used_q;
        mod_d  = mod_q;
        for (int i = 0; i < NUM_DESC; i++) desc_d[i] = desc_q[i];
        if (mark_used) used_d[mark_idx] = 1'b1;
        if (mark_mod)  mod_d[mark_idx]  = 1'b1;
        // A fresh load starts the segment with clean flags
        if (load_en) begin
            desc_d[load_idx] = load_desc;
            used_d[load_idx] = 1'b0;
            mod_d[load_idx]  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            used_q <= '0;
            mod_q  <= '0;
            for (int i = 0; i < NUM_DESC; i++) desc_q[i] <= '0;
        end else begin
            used_q <= used_d;
            mod_q  <= mod_d;
            for (int i = 0; i < NUM_DESC; i++) desc_q[i] <= desc_d[i];
        end
    end

    generate
        for (genvar g = 0; g < NUM_DESC; g++) begin : g_out
            assign descs[g] = desc_q[g];
        end
    endgenerate

    assign stat_used = used_q[stat_idx];
    assign stat_mod  = mod_q[stat_idx];

    // R10: a mark request not overridden by a load leaves the flag set
    assert_used_sticks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mark_used && !(load_en && load_idx == mark_idx)) |=> used_q[$past(mark_idx)]);
    // R10: a load clears the flags of its descriptor
    assert_load_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (!used_q[$past(load_idx)] && !mod_q[$past(load_idx)]));
endmodule

// File: rtl/seg_match_unit.sv
module seg_match_unit #(
    parameter int NUM_DESC = 32,
    localparam int IDX_W = $clog2(NUM_DESC)
) (
    input  seg_xlate_pkg::desc_t                  descs [NUM_DESC],
    input  logic [seg_xlate_pkg::LA_W-1:0]        laddr,
    input  logic [seg_xlate_pkg::SPACE_W-1:0]     cyc_space,
    output logic                                  any_hit,
    output logic [IDX_W-1:0]                      win_idx,
    output logic                                  win_wprot,
    output logic [seg_xlate_pkg::LA_W-1:0]        phys
);
    import seg_xlate_pkg::*;

    logic [NUM_DESC-1:0] hit_vec;

    generate
        for (genvar g = 0; g < NUM_DESC; g++) begin : g_cmp
            logic addr_ok, space_ok;
            assign addr_ok  = ((laddr ^ descs[g].lbase) & descs[g].lmask) == '0;
            assign space_ok = ((cyc_space ^ descs[g].space) & descs[g].smask) == '0;
            assign hit_vec[g] = descs[g].enable && addr_ok && space_ok;
        end
    endgenerate

    // Lowest index wins: scan from the top so the last assignment is the smallest hit
    always_comb begin
        win_idx = '0;
        for (int i = NUM_DESC - 1; i >= 0; i--) begin
            if (hit_vec[i]) win_idx = IDX_W'(i);
        end
    end

    assign any_hit   = |hit_vec;
    assign win_wprot = descs[win_idx].wprot;
    assign phys      = (descs[win_idx].pbase & descs[win_idx].lmask)
                     | (laddr & ~descs[win_idx].lmask);
endmodule

// File: rtl/seg_xlate_top.sv
module seg_xlate_top #(
    parameter int NUM_DESC = 32,
    parameter int FC_W     = 4,
    localparam int IDX_W = $clog2(NUM_DESC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             desc_wr_en,
    input  logic [IDX_W-1:0] desc_wr_idx,
    input  logic [15:0]      desc_wr_lbase,
    input  logic [15:0]      desc_wr_lmask,
    input  logic [15:0]      desc_wr_pbase,
    input  logic [7:0]       desc_wr_space,
    input  logic [7:0]       desc_wr_smask,
    input  logic             desc_wr_enable,
    input  logic             desc_wr_wprot,
    input  logic             tbl_wr_en,
    input  logic [FC_W:0]    tbl_wr_addr,
    input  logic [7:0]       tbl_wr_data,
    input  logic             xl_valid,
    input  logic [FC_W-1:0]  xl_fc,
    input  logic [15:0]      xl_laddr,
    input  logic             xl_write,
    input  logic [IDX_W-1:0] stat_rd_idx,
    output logic             stat_used,
    output logic             stat_mod,
    output logic [15:0]      pa_out,
    output logic             pa_valid,
    output logic             wr_inhibit,
    output logic             fault,
    output logic             wr_viol,
    output logic             undef_seg,
    output logic [IDX_W-1:0] hit_idx
);
    import seg_xlate_pkg::*;

    typedef struct packed {
        logic [LA_W-1:0]  pa;
        logic             pa_vld;
        logic             winh;
        logic             flt;
        logic             viol;
        logic             undef;
        logic [IDX_W-1:0] hit;
        logic             vld_prev;
    } xl_state_t;

    xl_state_t st_d, st_q;

    desc_t              descs [NUM_DESC];
    desc_t              new_desc;
    logic [SPACE_W-1:0] cyc_space;
    logic               any_hit, win_wprot;
    logic [IDX_W-1:0]   win_idx;
    logic [LA_W-1:0]    phys;
    logic               first_cyc, ok_xl, mark_used, mark_mod;

    assign new_desc = '{lbase: desc_wr_lbase, lmask: desc_wr_lmask, pbase: desc_wr_pbase,
                        space: desc_wr_space, smask: desc_wr_smask,
                        enable: desc_wr_enable, wprot: desc_wr_wprot};

    seg_space_table #(.FC_W(FC_W)) i_table (
        .clk(clk), .rst_n(rst_n),
        .wr_en(tbl_wr_en), .wr_addr(tbl_wr_addr), .wr_data(tbl_wr_data),
        .rd_fc(xl_fc), .rd_space(cyc_space)
    );

    seg_desc_store #(.NUM_DESC(NUM_DESC)) i_store (
        .clk(clk), .rst_n(rst_n),
        .load_en(desc_wr_en), .load_idx(desc_wr_idx), .load_desc(new_desc),
        .mark_used(mark_used), .mark_mod(mark_mod), .mark_idx(win_idx),
        .stat_idx(stat_rd_idx), .stat_used(stat_used), .stat_mod(stat_mod),
        .descs(descs)
    );

    seg_match_unit #(.NUM_DESC(NUM_DESC)) i_match (
        .descs(descs), .laddr(xl_laddr), .cyc_space(cyc_space),
        .any_hit(any_hit), .win_idx(win_idx), .win_wprot(win_wprot), .phys(phys)
    );

    // Successful translation: a hit that is not a write into a protected segment
    assign ok_xl     = xl_valid && any_hit && !(xl_write && win_wprot);
    assign first_cyc = xl_valid && !st_q.vld_prev;
    assign mark_used = first_cyc && ok_xl;
    assign mark_mod  = first_cyc && ok_xl && xl_write;

    always_comb begin
        st_d          = '0;
        st_d.vld_prev = xl_valid;
        if (xl_valid) begin
            st_d.hit   = any_hit ? win_idx : '0;
            st_d.undef = !any_hit;
            st_d.viol  = any_hit && xl_write && win_wprot;
            st_d.flt   = st_d.undef || st_d.viol;
            st_d.pa_vld = ok_xl;
            st_d.winh  = ok_xl && win_wprot;
            st_d.pa    = ok_xl ? phys : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pa_out     = st_q.pa;
    assign pa_valid   = st_q.pa_vld;
    assign wr_inhibit = st_q.winh;
    assign fault      = st_q.flt;
    assign wr_viol    = st_q.viol;
    assign undef_seg  = st_q.undef;
    assign hit_idx    = st_q.hit;

    // R7, R9: a mapped address never coexists with a fault
    assert_valid_excludes_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(pa_valid && fault));
    // R8: write inhibit only ever accompanies a mapped address
    assert_inhibit_with_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_inhibit |-> pa_valid);
    // R9: undefined access always raises the fault output
    assert_undef_faults_R9: assert property (@(posedge clk) disable iff (!rst_n)
        undef_seg |-> (fault && !wr_viol));
    // R11: idle cycle clears every result one clock later
    assert_idle_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !xl_valid |=> !(pa_valid || fault || wr_inhibit || undef_seg || wr_viol));
    // R7: a read can never be a write violation
    assert_read_no_viol_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_valid && !xl_write) |=> !wr_viol);
endmodule

// File: tb/test_seg_xlate_top.sv
module test_seg_xlate_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        desc_wr_en = 1'b0;
    logic [4:0]  desc_wr_idx = '0;
    logic [15:0] desc_wr_lbase = '0, desc_wr_lmask = '0, desc_wr_pbase = '0;
    logic [7:0]  desc_wr_space = '0, desc_wr_smask = '0;
    logic        desc_wr_enable = 1'b0, desc_wr_wprot = 1'b0;
    logic        tbl_wr_en = 1'b0;
    logic [4:0]  tbl_wr_addr = '0;
    logic [7:0]  tbl_wr_data = '0;
    logic        xl_valid = 1'b0;
    logic [3:0]  xl_fc = '0;
    logic [15:0] xl_laddr = '0;
    logic        xl_write = 1'b0;
    logic [4:0]  stat_rd_idx = '0;
    logic        stat_used, stat_mod, pa_valid, wr_inhibit, fault, wr_viol, undef_seg;
    logic [15:0] pa_out;
    logic [4:0]  hit_idx;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_xlate_top i_seg_xlate_top (
        .clk(clk), .rst_n(rst_n),
        .desc_wr_en(desc_wr_en), .desc_wr_idx(desc_wr_idx),
        .desc_wr_lbase(desc_wr_lbase), .desc_wr_lmask(desc_wr_lmask),
        .desc_wr_pbase(desc_wr_pbase), .desc_wr_space(desc_wr_space),
        .desc_wr_smask(desc_wr_smask), .desc_wr_enable(desc_wr_enable),
        .desc_wr_wprot(desc_wr_wprot),
        .tbl_wr_en(tbl_wr_en), .tbl_wr_addr(tbl_wr_addr), .tbl_wr_data(tbl_wr_data),
        .xl_valid(xl_valid), .xl_fc(xl_fc), .xl_laddr(xl_laddr), .xl_write(xl_write),
        .stat_rd_idx(stat_rd_idx), .stat_used(stat_used), .stat_mod(stat_mod),
        .pa_out(pa_out), .pa_valid(pa_valid), .wr_inhibit(wr_inhibit), .fault(fault),
        .wr_viol(wr_viol), .undef_seg(undef_seg), .hit_idx(hit_idx)
    );

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic load_desc(int idx, logic [15:0] lb, logic [15:0] lm, logic [15:0] pb,
                             logic [7:0] sp, logic [7:0] sm, logic en, logic wp);
        @(negedge clk);
        desc_wr_en = 1'b1; desc_wr_idx = 5'(idx);
        desc_wr_lbase = lb; desc_wr_lmask = lm; desc_wr_pbase = pb;
        desc_wr_space = sp; desc_wr_smask = sm; desc_wr_enable = en; desc_wr_wprot = wp;
        @(negedge clk);
        desc_wr_en = 1'b0;
    endtask

    task automatic write_tbl(logic [4:0] addr, logic [7:0] val);
        @(negedge clk);
        tbl_wr_en = 1'b1; tbl_wr_addr = addr; tbl_wr_data = val;
        @(negedge clk);
        tbl_wr_en = 1'b0;
    endtask

    // One-cycle translation; leaves the caller at the negedge where results are due
    task automatic xlate(logic [3:0] fc, logic [15:0] la, logic wr);
        @(negedge clk);
        xl_valid = 1'b1; xl_fc = fc; xl_laddr = la; xl_write = wr;
        @(negedge clk);
        xl_valid = 1'b0;
    endtask

    task automatic expect_hit(string req, logic [15:0] pa, logic [4:0] idx, logic winh);
        check(req, "pa_valid", 32'(pa_valid), 1);
        check(req, "pa_out", 32'(pa_out), 32'(pa));
        check(req, "hit_idx", 32'(hit_idx), 32'(idx));
        check(req, "wr_inhibit", 32'(wr_inhibit), 32'(winh));
        check(req, "fault", 32'(fault), 0);
    endtask

    task automatic expect_undef(string req);
        check(req, "undef_seg", 32'(undef_seg), 1);
        check(req, "fault", 32'(fault), 1);
        check(req, "pa_valid", 32'(pa_valid), 0);
    endtask

    task automatic expect_flags(string req, int idx, logic used, logic md);
        stat_rd_idx = 5'(idx);
        #1;
        check(req, "used", 32'(stat_used), 32'(used));
        check(req, "modified", 32'(stat_mod), 32'(md));
    endtask

    task automatic t_reset;
        check("R11", "reset pa_valid", 32'(pa_valid), 0);
        check("R11", "reset fault", 32'(fault), 0);
        check("R11", "reset undef", 32'(undef_seg), 0);
        expect_flags("R11", 0, 1'b0, 1'b0);
    endtask

    task automatic t_table_and_basic;
        write_tbl(5'h04, 8'h12);   // R1: entry 2
        write_tbl(5'h05, 8'hFF);   // R1: odd address ignored
        write_tbl(5'h1E, 8'h77);   // R1: entry 15
        load_desc(3, 16'h1200, 16'hFF00, 16'hAB00, 8'h12, 8'hFF, 1'b1, 1'b0);
        xlate(4'd2, 16'h1234, 1'b0);
        expect_hit("R1_R2_R5", 16'hAB34, 5'd3, 1'b0);
        xlate(4'd2, 16'h1334, 1'b0);
        expect_undef("R2_R9");
        xlate(4'd15, 16'h1234, 1'b0);
        expect_undef("R3");       // entry 15 = 0x77 differs from space 0x12
    endtask

    task automatic t_space_dontcare_priority;
        load_desc(5, 16'h1200, 16'hF000, 16'h5000, 8'h00, 8'h00, 1'b1, 1'b0);
        xlate(4'd15, 16'h1234, 1'b0);
        expect_hit("R3_R5", 16'h5234, 5'd5, 1'b0);
        xlate(4'd2, 16'h1234, 1'b0);
        expect_hit("R6", 16'hAB34, 5'd3, 1'b0);
        load_desc(3, 16'h1200, 16'hFF00, 16'hAB00, 8'h12, 8'hFF, 1'b0, 1'b0);
        xlate(4'd2, 16'h1234, 1'b0);
        expect_hit("R4", 16'h5234, 5'd5, 1'b0);
    endtask

    task automatic t_write_protect;
        load_desc(1, 16'h8000, 16'h8000, 16'h0000, 8'h00, 8'h00, 1'b1, 1'b1);
        xlate(4'd0, 16'h9ABC, 1'b0);
        expect_hit("R8", 16'h1ABC, 5'd1, 1'b1);
        xlate(4'd0, 16'h9ABC, 1'b1);
        check("R7", "pa_valid", 32'(pa_valid), 0);
        check("R7", "fault", 32'(fault), 1);
        check("R7", "wr_viol", 32'(wr_viol), 1);
        check("R7", "wr_inhibit", 32'(wr_inhibit), 0);
        expect_flags("R7_R10", 1, 1'b1, 1'b0);
    endtask

    task automatic t_status;
        expect_flags("R10", 5, 1'b1, 1'b0);
        xlate(4'd15, 16'h1234, 1'b1);
        expect_flags("R10", 5, 1'b1, 1'b1);
        load_desc(7, 16'h4000, 16'hFF00, 16'h4100, 8'h00, 8'h00, 1'b1, 1'b0);
        @(negedge clk);
        xl_valid = 1'b1; xl_fc = 4'd0; xl_laddr = 16'h4012; xl_write = 1'b0;
        @(negedge clk);
        xl_write = 1'b1;          // still the same assertion: no modified update
        @(negedge clk);
        expect_hit("R10", 16'h4112, 5'd7, 1'b0);
        xl_valid = 1'b0;
        expect_flags("R10", 7, 1'b1, 1'b0);
        @(negedge clk);
        check("R11", "idle pa_valid", 32'(pa_valid), 0);
        check("R11", "idle hit_idx", 32'(hit_idx), 0);
        load_desc(5, 16'h1200, 16'hF000, 16'h5000, 8'h00, 8'h00, 1'b1, 1'b0);
        expect_flags("R10", 5, 1'b0, 1'b0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_table_and_basic();
        t_space_dontcare_priority();
        t_write_protect();
        t_status();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule